// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a 32-bit timer that counts downward from a programmable start value. Software reaches it through a small word-wide register window with write strobes and a combinational read path. It uses five registers: control, status, load, compare and a read-only view of the live count. The count steps once for every (N+1) pulses of an input tick-enable, where N is a 12-bit divider held in the control register. Counting needs the enable bit set and a non-zero clock-source field.

Each time a counting step brings the count to the compare value, the block raises a sticky status flag. Software clears this flag by writing a one to it. The flag drives a level interrupt through an enable gate, and it moves an output pin in one of four ways. When the count passes zero, the block either restarts it from the load register or lets it wrap to all ones. Software schedules a future event by reading the count and writing the count minus the delay into compare. Two control bits change how the count is seeded. One makes a load write overwrite the count at once. The other makes the start of counting copy the load value into the count. A software reset bit returns the block to a quiet state within one cycle.

Top module: `intv_timer`

## Requirements
- R1: After hardware reset, control, status, compare and count read 0, load reads 0xFFFFFFFF, and irq and cmp_out are 0.
- R2: Register byte offsets are control 0x00, status 0x04, load 0x08, compare 0x0C and count 0x10. Writes to the count offset are ignored. Unmapped offsets read 0. Control fields are: bit 0 enable, bit 1 start-load mode, bit 2 interrupt enable, bit 3 reload, bits 15:4 divider, bit 16 soft reset, bit 17 load-overwrite, bits 23:22 pin mode, bits 25:24 clock source. All other control bits read 0.
- R3: While counting is allowed, the count takes one step every divider+1 tick_en pulses.
- R4: Each step decrements a non-zero count by exactly one.
- R5: The count holds its value when enable is 0, when the clock-source field is 0, or when tick_en stays low.
- R6: With bit 17 set, a load write places the written value in the count on the same clock edge. With bit 17 clear, a load write leaves the count unchanged.
- R7: A control write that sets enable while enable was 0 copies the load register into the count if bit 1 is 1. If bit 1 is 0, the count keeps its value.
- R8: A step from a count of 0 gives the load value when reload is 1, and 0xFFFFFFFF when reload is 0.
- R9: When a step makes the count equal to compare, status bit 0 becomes 1. The bit stays 1 until a status write with bit 0 set. A status write with bit 0 clear has no effect. If a set and a clear fall in the same cycle, the set wins.
- R10: irq is 1 exactly while status bit 0 and the interrupt-enable bit are both 1.
- R11: On a compare event, cmp_out reacts to the pin mode: 0 leaves it unchanged, 1 toggles it, 2 drives it to 0 and 3 drives it to 1.
- R12: A control write with bit 16 set clears the count, the status flag, cmp_out and every control field. Control then reads 0x00010000 for one cycle and 0 afterwards. Load and compare keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count tick qualifier, one cycle per pulse |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt request |
| cmp_out | output | 1 | Compare-driven output pin |

## Verification
The compare event is the hardest case to reach. It needs a decrementing step to land on the compare value exactly, and in normal free counting that happens only once every 2^32 steps. The stimulus first stops the timer and seeds a small count through the load-overwrite path. It then writes compare as that count minus a short delay and restarts with divider 0. The event therefore falls a known number of cycles after the enabling write. This lets each pin mode, the flag, the interrupt gate and a soft reset in mid-count be checked at exact cycles.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

  localparam int unsigned OFS_CTRL = 32'h00;
  localparam int unsigned OFS_STAT = 32'h04;
  localparam int unsigned OFS_LOAD = 32'h08;
  localparam int unsigned OFS_CMP  = 32'h0C;
  localparam int unsigned OFS_CNT  = 32'h10;

  localparam int unsigned B_EN     = 0;
  localparam int unsigned B_ENMOD  = 1;
  localparam int unsigned B_IE     = 2;
  localparam int unsigned B_RLD    = 3;
  localparam int unsigned B_PRESC  = 4;
  localparam int unsigned B_SWR    = 16;
  localparam int unsigned B_OVW    = 17;
  localparam int unsigned B_OM     = 22;
  localparam int unsigned B_CLKSRC = 24;
  localparam int unsigned PRESC_MAX_W = 12;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic [1:0] clksrc;
    pin_mode_e  om;
    logic       ovw;
    logic       rld;
    logic       ie;
    logic       enmod;
    logic       en;
  } ctrl_t;

endpackage

// File: rtl/intv_timer_presc.sv
module intv_timer_presc #(
  parameter int unsigned PRESC_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick_en,
  input  logic               clr,
  input  logic [PRESC_W-1:0] div,
  output logic               step
);

  logic [PRESC_W-1:0] pcnt_q, pcnt_d;
  logic               pcnt_ce;
  logic               at_end;

  assign at_end = (pcnt_q >= div);
  assign step   = run && tick_en && !clr && at_end;

  always_comb begin
    pcnt_ce = 1'b0;
    pcnt_d  = pcnt_q;
    if (clr || !run) begin
      pcnt_ce = (pcnt_q != '0);
      pcnt_d  = '0;
    end else if (tick_en) begin
      pcnt_ce = 1'b1;
      pcnt_d  = at_end ? '0 : pcnt_q + PRESC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_ce) pcnt_q <= pcnt_d;
  end

  // R3: a step always restarts the divider phase
  p_presc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pcnt_q == '0));

endmodule

// File: rtl/intv_timer_core.sv
module intv_timer_core
  import intv_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              step,
  input  logic              rld,
  input  pin_mode_e         om,
  input  logic              ovw_wr,
  input  logic [DATA_W-1:0] ovw_val,
  input  logic              en_load,
  input  logic [DATA_W-1:0] load_q,
  input  logic [DATA_W-1:0] cmp_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              match,
  output logic              pin_q
);

  logic [DATA_W-1:0] cnt_d, step_val;
  logic              cnt_ce;
  logic              pin_d, pin_ce;
  logic              stepping;

  assign stepping = step && !sw_rst && !ovw_wr && !en_load;

  always_comb begin
    if (cnt_q == '0) step_val = rld ? load_q : {DATA_W{1'b1}};
    else             step_val = cnt_q - DATA_W'(1);
  end

  always_comb begin
    cnt_ce = 1'b1;
    cnt_d  = cnt_q;
    if (sw_rst)        cnt_d = '0;
    else if (ovw_wr)   cnt_d = ovw_val;
    else if (en_load)  cnt_d = load_q;
    else if (stepping) cnt_d = step_val;
    else               cnt_ce = 1'b0;
  end

  assign match = stepping && (step_val == cmp_q);

  always_comb begin
    pin_ce = 1'b0;
    pin_d  = pin_q;
    if (sw_rst) begin
      pin_ce = 1'b1;
      pin_d  = 1'b0;
    end else if (match) begin
      pin_ce = 1'b1;
      unique case (om)
        PIN_HOLD:   pin_d = pin_q;
        PIN_TOGGLE: pin_d = !pin_q;
        PIN_CLEAR:  pin_d = 1'b0;
        PIN_SET:    pin_d = 1'b1;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_ce) pin_q <= pin_d;
  end

  // R4: plain step decrements by one
  p_step_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DATA_W'(1)));

  // R5: no step and no seeding leaves the count alone
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !sw_rst && !ovw_wr && !en_load) |=> $stable(cnt_q));

  // R8: free-running wrap through zero
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stepping && cnt_q == '0 && !rld) |=> (&cnt_q));

  // R11: set mode drives the pin high
  p_pin_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (match && om == PIN_SET) |=> pin_q);

  // R12: soft reset zeroes count and pin
  p_swr_cnt_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (cnt_q == '0 && !pin_q));

endmodule

// File: rtl/intv_timer_regs.sv
module intv_timer_regs
  import intv_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PRESC_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               match,
  input  logic [DATA_W-1:0]  cnt_q,
  output ctrl_t              ctrl_q,
  output logic [PRESC_W-1:0] div_q,
  output logic [DATA_W-1:0]  load_q,
  output logic [DATA_W-1:0]  cmp_q,
  output logic               flag_q,
  output logic               sw_rst,
  output logic               ovw_wr,
  output logic               en_load,
  output logic [DATA_W-1:0]  rdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_CMP  = ADDR_W'(OFS_CMP);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);

  logic               swr_q;
  logic               wr_ok;
  logic               wr_ctrl, wr_stat, wr_load, wr_cmp;
  ctrl_t              ctrl_d, ctrl_w;
  logic [PRESC_W-1:0] div_d;
  logic               ctrl_ce;
  logic               flag_d, flag_ce;

  assign wr_ok   = wr && !swr_q;
  assign wr_ctrl = wr_ok && (addr == A_CTRL);
  assign wr_stat = wr_ok && (addr == A_STAT);
  assign wr_load = wr_ok && (addr == A_LOAD);
  assign wr_cmp  = wr_ok && (addr == A_CMP);

  assign sw_rst  = wr_ctrl && wdata[B_SWR];
  assign ovw_wr  = wr_load && ctrl_q.ovw;

  always_comb begin
    ctrl_w.en     = wdata[B_EN];
    ctrl_w.enmod  = wdata[B_ENMOD];
    ctrl_w.ie     = wdata[B_IE];
    ctrl_w.rld    = wdata[B_RLD];
    ctrl_w.ovw    = wdata[B_OVW];
    ctrl_w.om     = pin_mode_e'(wdata[B_OM +: 2]);
    ctrl_w.clksrc = wdata[B_CLKSRC +: 2];
  end

  assign en_load = wr_ctrl && !sw_rst && ctrl_w.en && ctrl_w.enmod && !ctrl_q.en;

  always_comb begin
    ctrl_ce = 1'b1;
    ctrl_d  = ctrl_q;
    div_d   = div_q;
    if (swr_q || sw_rst) begin
      ctrl_d = '0;
      div_d  = '0;
    end else if (wr_ctrl) begin
      ctrl_d = ctrl_w;
      div_d  = wdata[B_PRESC +: PRESC_W];
    end else begin
      ctrl_ce = 1'b0;
    end
  end

  always_comb begin
    flag_ce = 1'b1;
    flag_d  = flag_q;
    if (sw_rst)                      flag_d = 1'b0;
    else if (match)                  flag_d = 1'b1;
    else if (wr_stat && wdata[0])    flag_d = 1'b0;
    else                             flag_ce = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
    end else if (ctrl_ce) begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swr_q <= 1'b0;
    else        swr_q <= sw_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= {DATA_W{1'b1}};
    else if (wr_load) load_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[B_EN]              = ctrl_q.en;
        rdata[B_ENMOD]           = ctrl_q.enmod;
        rdata[B_IE]              = ctrl_q.ie;
        rdata[B_RLD]             = ctrl_q.rld;
        rdata[B_PRESC +: PRESC_W] = div_q;
        rdata[B_SWR]             = swr_q;
        rdata[B_OVW]             = ctrl_q.ovw;
        rdata[B_OM +: 2]         = ctrl_q.om;
        rdata[B_CLKSRC +: 2]     = ctrl_q.clksrc;
      end
      A_STAT:  rdata[0] = flag_q;
      A_LOAD:  rdata    = load_q;
      A_CMP:   rdata    = cmp_q;
      A_CNT:   rdata    = cnt_q;
      default: rdata    = '0;
    endcase
  end

  // R9: compare event raises the flag, even against a clearing write
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !sw_rst) |=> flag_q);

  // R12: reset bit lives exactly one cycle
  p_swr_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    swr_q |=> !swr_q);

  // R12: fields are cleared by the soft reset
  p_swr_ctrl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (ctrl_q == '0 && div_q == '0 && !flag_q));

  // R7: start-load only happens from a stopped timer
  p_enload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_load |-> !ctrl_q.en);

endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned PRESC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              cmp_out
);

  ctrl_t              ctrl_q;
  logic [PRESC_W-1:0] div_q;
  logic [DATA_W-1:0]  load_q, cmp_q, cnt_q;
  logic               flag_q, sw_rst, ovw_wr, en_load;
  logic               match, step, run;

  initial begin
    if (PRESC_W > PRESC_MAX_W || DATA_W < 26)
      $error("intv_timer: parameter out of range");
  end

  intv_timer_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PRESC_W(PRESC_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .wdata  (bus_wdata),
    .match  (match),
    .cnt_q  (cnt_q),
    .ctrl_q (ctrl_q),
    .div_q  (div_q),
    .load_q (load_q),
    .cmp_q  (cmp_q),
    .flag_q (flag_q),
    .sw_rst (sw_rst),
    .ovw_wr (ovw_wr),
    .en_load(en_load),
    .rdata  (bus_rdata)
  );

  assign run = ctrl_q.en && (ctrl_q.clksrc != 2'd0);

  intv_timer_presc #(.PRESC_W(PRESC_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .tick_en(tick_en),
    .clr    (sw_rst || en_load),
    .div    (div_q),
    .step   (step)
  );

  intv_timer_core #(.DATA_W(DATA_W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_rst (sw_rst),
    .step   (step),
    .rld    (ctrl_q.rld),
    .om     (ctrl_q.om),
    .ovw_wr (ovw_wr),
    .ovw_val(bus_wdata),
    .en_load(en_load),
    .load_q (load_q),
    .cmp_q  (cmp_q),
    .cnt_q  (cnt_q),
    .match  (match),
    .pin_q  (cmp_out)
  );

  assign irq = flag_q && ctrl_q.ie;

  // R10: a cleared flag can never leave the interrupt asserted
  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q) |-> !irq);

  // R5: no counting without a clock source
  p_no_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.clksrc == 2'd0) |-> !step);

endmodule

// File: tb/intv_timer_test.sv
module intv_timer_test;

  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_LOAD = 5'h08,
                         A_CMP = 5'h0C, A_CNT = 5'h10;
  localparam logic [31:0] C_EN = 32'h1, C_ENMOD = 32'h2, C_IE = 32'h4,
                          C_RLD = 32'h8, C_SWR = 32'h1_0000, C_OVW = 32'h2_0000,
                          C_SRC = 32'h100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, cmp_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit tick_alt = 0;
  bit tick_hold = 1;

  intv_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .cmp_out(cmp_out)
  );

  always #10 clk = ~clk;

  always @(negedge clk) tick_en <= tick_alt ? ~tick_en : tick_hold;

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1", "ctrl", v, 0);
    rd(A_STAT, v); chk("R1", "status", v, 0);
    rd(A_LOAD, v); chk("R1", "load", v, 32'hFFFF_FFFF);
    rd(A_CMP, v);  chk("R1", "compare", v, 0);
    rd(A_CNT, v);  chk("R1", "count", v, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "pin", cmp_out, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(A_CTRL, 32'hFFFE_FFFF);
    rd(A_CTRL, v); chk("R2", "ctrl readback", v, 32'h03C2_FFFF);
    wr(A_CTRL, C_OVW);
    wr(A_LOAD, 32'd100);
    rd(A_CNT, v); chk("R6", "overwrite", v, 32'd100);
    wr(A_CNT, 32'd5);
    rd(A_CNT, v); chk("R2", "count write ignored", v, 32'd100);
    rd(5'h14, v); chk("R2", "unmapped", v, 0);
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'd50);
    rd(A_CNT, v); chk("R6", "no overwrite", v, 32'd100);
  endtask

  task automatic t_hold();
    logic [31:0] a, b;
    rd(A_CNT, a); wait_n(10); rd(A_CNT, b); chk("R5", "disabled", b, a);
    wr(A_CTRL, C_EN);
    rd(A_CNT, a); wait_n(10); rd(A_CNT, b); chk("R5", "no clock source", b, a);
    tick_hold = 0;
    wr(A_CTRL, C_EN | C_SRC);
    rd(A_CNT, a); wait_n(10); rd(A_CNT, b); chk("R5", "no tick", b, a);
    tick_hold = 1;
  endtask

  task automatic t_presc();
    logic [31:0] a, b;
    wr(A_CTRL, C_EN | C_SRC | (32'd2 << 4));
    rd(A_CNT, a); wait_n(9); rd(A_CNT, b); chk("R3", "div 3 over 9", a - b, 3);
    wr(A_CTRL, C_EN | C_SRC);
    rd(A_CNT, a); wait_n(7); rd(A_CNT, b); chk("R4", "div 1 over 7", a - b, 7);
    tick_alt = 1;
    wr(A_CTRL, C_EN | C_SRC | (32'd1 << 4));
    rd(A_CNT, a); wait_n(8); rd(A_CNT, b); chk("R3", "half-rate tick", a - b, 2);
    tick_alt = 0;
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(A_CTRL, C_OVW);
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, C_EN | C_OVW | C_RLD | C_SRC);
    wait_n(5); rd(A_CNT, v); chk("R8", "reload", v, 32'd2);
    wr(A_CTRL, C_OVW);
    wr(A_LOAD, 32'd3);
    wr(A_CTRL, C_EN | C_OVW | C_SRC);
    wait_n(5); rd(A_CNT, v); chk("R8", "wrap", v, 32'hFFFF_FFFE);
  endtask

  task automatic t_enmode();
    logic [31:0] v, a;
    wr(A_CTRL, C_OVW);
    wr(A_LOAD, 32'd77);
    wr(A_CTRL, 32'h0);
    wr(A_LOAD, 32'd500);
    rd(A_CNT, v); chk("R6", "count kept", v, 32'd77);
    wr(A_CTRL, C_EN | C_ENMOD | C_SRC);
    rd(A_CNT, v); chk("R7", "start-load", v, 32'd500);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, a);
    wr(A_CTRL, C_EN | C_SRC);
    rd(A_CNT, v); chk("R7", "no start-load", v, a);
  endtask

  task automatic arm(input logic [31:0] start, input int dly,
                     input logic [1:0] om, input logic ie);
    wr(A_CTRL, C_OVW);
    wr(A_STAT, 32'h1);
    wr(A_LOAD, start);
    wr(A_CMP, start - 32'(dly));
    wr(A_CTRL, C_EN | C_OVW | C_SRC | (32'(ie) << 2) | (32'(om) << 22));
  endtask

  task automatic t_compare();
    logic [31:0] v;
    arm(32'd20, 5, 2'd1, 1'b1);
    rd(A_STAT, v); chk("R9", "flag before event", v, 0);
    wait_n(6);
    rd(A_STAT, v); chk("R9", "flag after event", v, 1);
    chk("R10", "irq on", irq, 1);
    chk("R11", "toggle", cmp_out, 1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R9", "write 0 no effect", v, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R9", "write 1 clears", v, 0);
    chk("R10", "irq off", irq, 0);
    arm(32'd40, 4, 2'd3, 1'b0);
    wait_n(6);
    rd(A_STAT, v); chk("R10", "flag set, ie clear", {v[0], irq}, 2'b10);
    chk("R11", "set", cmp_out, 1);
    arm(32'd40, 4, 2'd2, 1'b0); wait_n(6); chk("R11", "clear", cmp_out, 0);
    arm(32'd40, 4, 2'd1, 1'b0); wait_n(6); chk("R11", "toggle up", cmp_out, 1);
    arm(32'd40, 4, 2'd0, 1'b0); wait_n(6); chk("R11", "hold", cmp_out, 1);
  endtask

  task automatic t_swr();
    logic [31:0] v;
    arm(32'd30, 3, 2'd3, 1'b1);
    wait_n(5);
    chk("R12", "pre irq", irq, 1);
    wr(A_CTRL, C_SWR | C_EN | C_SRC);
    rd(A_CTRL, v); chk("R12", "ctrl during", v, C_SWR);
    rd(A_STAT, v); chk("R12", "status", v, 0);
    rd(A_CNT, v);  chk("R12", "count", v, 0);
    chk("R12", "pin", cmp_out, 0);
    chk("R12", "irq", irq, 0);
    wait_n(1);
    rd(A_CTRL, v); chk("R12", "ctrl after", v, 0);
    rd(A_LOAD, v); chk("R12", "load kept", v, 32'd30);
    rd(A_CMP, v);  chk("R12", "compare kept", v, 32'd27);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_map();
    t_hold();
    t_presc();
    t_zero();
    t_enmode();
    t_compare();
    t_swr();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule